// File: doc/BRIEF.md
# Serial SRAM Access Engine

This block is the byte-level data path between a two-wire serial client front end and a byte-wide working memory. The front end detects Start and Stop, matches the client address and shifts bits. It hands this engine one event per byte: a received byte, a byte to transmit, or the host's acknowledge bit. The engine holds the memory array and an address pointer that survives from one transaction to the next. A write transaction loads the pointer from two address bytes and then stores data bytes at their acknowledge point. A read transaction streams bytes from wherever the pointer stands.

A write that carries only the two address bytes, followed by a repeated Start and a read, gives a random read. The pointer wraps from the last location to zero in both directions, so bursts have no length limit. A three-bit block-protect input guards an upper fraction of the array. A data byte aimed there is refused and not stored, the pointer stays put, and the engine ignores everything until the next Start. An abort input from the store sequencer drops the transaction at once. Bytes already committed stay in memory.

Received bytes use a valid/ready handshake: a byte is taken on any cycle where `rx_valid` and `rx_ready` are both high, and `rx_ready` is low only while a read is in progress. Transmit bytes use the same handshake: `tx_data` holds steady while `tx_valid` is high and `tx_ready` is low, and the byte is consumed on the cycle both are high. Start, Stop, transaction begin, host acknowledge and abort are plain single-cycle pulses.

Top module: `sram_access_engine`

## Requirements
- R1: After reset `rx_ready` is 1 and `tx_valid`, `ack_valid`, `ack_ok` and `array_written` are 0.
- R2: After `xfer_begin` with `xfer_read`=0, the first byte taken sets the pointer bits above bit 7 from its low bits; its upper bits beyond the array size are ignored. The second byte sets pointer bits 7..0. Both bytes are answered with `ack_ok`=1.
- R3: Each later data byte is written to the pointer location when it is taken. `ack_valid`, `ack_ok`=1 and `array_written` are all raised in the following cycle, and the pointer then advances by one.
- R4: After `xfer_begin` with `xfer_read`=1, `tx_valid` rises two cycles later, carrying the byte at the pointer. `tx_data` holds while `tx_ready` is low, and the pointer advances on the transmit handshake.
- R5: A host acknowledge pulse with `host_nack`=0 makes the next byte valid two cycles later. One with `host_nack`=1 ends the read, and `xfer_begin` is then ignored until a Start.
- R6: The pointer wraps from the last location to 0 for both writes and reads.
- R7: A repeated Start after the address bytes keeps the pointer, so the following read begins at the loaded address.
- R8: The block-protect input covers the upper part of the array: 0 nothing, 1 the top 1/64, 2 the top 1/32, 3 the top 1/16, 4 the top 1/8, 5 the top 1/4, 6 the top 1/2, and 7 the whole array.
- R9: A data byte aimed at a protected location gets `ack_ok`=0 and is not stored. The pointer does not advance, and every later byte gets `ack_ok`=0 until a Start.
- R10: `abort` returns the engine to idle in the next cycle and drops a byte offered in the same cycle. Earlier committed bytes stay, and traffic is ignored until a Start.
- R11: Every byte taken is answered by `ack_valid` one cycle later. Bytes taken after a Stop and before the next Start get `ack_ok`=0 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| abort | input | 1 | Store sequencer abort pulse |
| bus_start | input | 1 | Start or repeated Start seen |
| bus_stop | input | 1 | Stop seen |
| xfer_begin | input | 1 | Client address matched, transaction begins |
| xfer_read | input | 1 | Direction of the beginning transaction, 1 = read |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Engine can take a received byte |
| rx_data | input | 8 | Received byte |
| ack_valid | output | 1 | Acknowledge decision for the byte taken last cycle |
| ack_ok | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Front end takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| host_ack_valid | input | 1 | Host acknowledge bit received |
| host_nack | input | 1 | 1 = host did not acknowledge |
| bp | input | 3 | Block-protect field |
| array_written | output | 1 | Pulse: a byte was written to the array |

## Verification
Answers to received bytes (`ack_valid`, `ack_ok`, `array_written`) come one cycle after the byte handshake. A transmit byte becomes valid two cycles after `xfer_begin` or after a continuing host acknowledge: one cycle to enter the fetch state and one for the synchronous memory read. The bench drives every input at the falling edge and samples at the next falling edge for answers, or at the second one for transmit bytes, so each check lands on the exact cycle the result is due. The pointer is observed only through reads, and a shadow copy of the array predicts every byte.

// File: rtl/sae_pkg.sv
package sae_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_ARMED,
    ST_ADDR_HI,
    ST_ADDR_LO,
    ST_DATA,
    ST_RFETCH,
    ST_RSEND,
    ST_RHOLD
  } eng_state_t;

  localparam int BYTE_W = 8;
  localparam int BP_W   = 3;
endpackage

// File: rtl/sae_mem.sv
module sae_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    if (re) rdata <= cells[addr];
  end
endmodule

// File: rtl/sae_guard.sv
module sae_guard #(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        bp,
  output logic              hit
);
  localparam int LW = ADDR_W + 1;
  localparam logic [LW-1:0] FULL = LW'(1) << ADDR_W;

  logic [LW-1:0] limit;

  always_comb begin
    case (bp)
      3'd0:    limit = FULL;
      3'd7:    limit = '0;
      default: limit = FULL - (FULL >> (3'd7 - bp));
    endcase
  end

  assign hit = {1'b0, addr} >= limit;
endmodule

// File: rtl/sae_ptr.sv
module sae_ptr #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic              inc,
  input  logic [7:0]        byte_in,
  output logic [ADDR_W-1:0] ptr
);
  localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  generate
    if (ADDR_W > 8) begin : g_wide
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (load_hi) ptr[ADDR_W-1:8] <= HI_W'(byte_in);
        else if (load_lo) ptr[7:0] <= byte_in;
        else if (inc)     ptr <= ptr + ADDR_W'(1);
      end

      // R2: loading the low byte leaves the high part alone
      a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (load_lo && !load_hi) |=> (ptr[ADDR_W-1:8] == $past(ptr[ADDR_W-1:8])));
    end else begin : g_narrow
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ptr <= '0;
        else if (load_lo) ptr <= ADDR_W'(byte_in);
        else if (inc)     ptr <= ptr + ADDR_W'(1);
      end
    end
  endgenerate

  // R6: advancing from the top location lands on zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load_hi && !load_lo && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/sram_access_engine.sv
module sram_access_engine
  import sae_pkg::*;
#(
  parameter int DEPTH = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       bus_start,
  input  logic       bus_stop,
  input  logic       xfer_begin,
  input  logic       xfer_read,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       ack_valid,
  output logic       ack_ok,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       host_ack_valid,
  input  logic       host_nack,
  input  logic [2:0] bp,
  output logic       array_written
);
  localparam int ADDR_W = $clog2(DEPTH);

  eng_state_t        st, st_nx;
  logic [ADDR_W-1:0] ptr;
  logic              prot_hit;
  logic              take, tx_fire;
  logic              mem_we, mem_re;
  logic              ld_hi, ld_lo, ptr_inc;
  logic [7:0]        mem_q;

  assign take     = rx_valid && rx_ready;
  assign tx_fire  = tx_valid && tx_ready;
  assign rx_ready = !(st inside {ST_RFETCH, ST_RSEND, ST_RHOLD});
  assign tx_valid = (st == ST_RSEND);
  assign tx_data  = mem_q;

  assign mem_we  = take && !abort && (st == ST_DATA) && !prot_hit;
  assign mem_re  = (st == ST_RFETCH) && !abort;
  assign ld_hi   = take && !abort && (st == ST_ADDR_HI);
  assign ld_lo   = take && !abort && (st == ST_ADDR_LO);
  assign ptr_inc = mem_we || (tx_fire && !abort);

  sae_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_hi (ld_hi),
    .load_lo (ld_lo),
    .inc     (ptr_inc),
    .byte_in (rx_data),
    .ptr     (ptr)
  );

  sae_guard #(.ADDR_W(ADDR_W)) u_guard (
    .addr (ptr),
    .bp   (bp),
    .hit  (prot_hit)
  );

  sae_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (ptr),
    .wdata (rx_data),
    .rdata (mem_q)
  );

  always_comb begin
    st_nx = st;
    if (abort)          st_nx = ST_WAIT;
    else if (bus_start) st_nx = ST_ARMED;
    else if (bus_stop)  st_nx = ST_WAIT;
    else begin
      case (st)
        ST_ARMED:   if (xfer_begin) st_nx = xfer_read ? ST_RFETCH : ST_ADDR_HI;
        ST_ADDR_HI: if (take) st_nx = ST_ADDR_LO;
        ST_ADDR_LO: if (take) st_nx = ST_DATA;
        ST_DATA:    if (take && prot_hit) st_nx = ST_WAIT;
        ST_RFETCH:  st_nx = ST_RSEND;
        ST_RSEND:   if (tx_fire) st_nx = ST_RHOLD;
        ST_RHOLD:   if (host_ack_valid) st_nx = host_nack ? ST_WAIT : ST_RFETCH;
        default:    st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= ST_WAIT;
      ack_valid     <= 1'b0;
      ack_ok        <= 1'b0;
      array_written <= 1'b0;
    end else begin
      st            <= st_nx;
      ack_valid     <= take;
      ack_ok        <= ld_hi || ld_lo || mem_we;
      array_written <= mem_we;
    end
  end

  // R3: every write into the array is answered with an acknowledge
  a_r3_write_acked: assert property (@(posedge clk) disable iff (!rst_n)
    array_written |-> (ack_valid && ack_ok));

  // R9: a refused byte never reaches the array
  a_r9_refused_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && !ack_ok) |-> !array_written);

  // R9: once locked out, only a Start reopens the engine
  a_r9_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && !bus_start) |=> (st == ST_WAIT));

  // R4: a byte on offer stays put until taken
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !abort && !bus_start && !bus_stop)
      |=> (tx_valid && $stable(tx_data)));

  // R4: the single memory port is never asked to read and write together
  a_r4_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R10: abort silences the engine on the next cycle
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!tx_valid && rx_ready && !array_written));
endmodule

// File: tb/tb_sram_access_engine.sv
module tb_sram_access_engine;
  localparam int DEPTH = 2048;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       abort = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic       xfer_begin = 1'b0, xfer_read = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_ready = 1'b0;
  logic       host_ack_valid = 1'b0, host_nack = 1'b0;
  logic [2:0] bp = '0;
  logic       rx_ready, ack_valid, ack_ok, tx_valid, array_written;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [DEPTH];

  always #2.5 clk = ~clk;

  sram_access_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .abort(abort), .bus_start(bus_start),
    .bus_stop(bus_stop), .xfer_begin(xfer_begin), .xfer_read(xfer_read),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .ack_valid(ack_valid), .ack_ok(ack_ok), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .host_ack_valid(host_ack_valid),
    .host_nack(host_nack), .bp(bp), .array_written(array_written)
  );

  // {bp, address, data}
  localparam logic [21:0] VEC [12] = '{
    {3'd0, 11'h000, 8'hA5}, {3'd0, 11'h7FF, 8'h3C},
    {3'd1, 11'h7E0, 8'h11}, {3'd1, 11'h7DF, 8'h22},
    {3'd2, 11'h7C0, 8'h2B}, {3'd3, 11'h77F, 8'h3D},
    {3'd4, 11'h700, 8'h33}, {3'd4, 11'h6FF, 8'h44},
    {3'd5, 11'h600, 8'h5E}, {3'd6, 11'h400, 8'h55},
    {3'd6, 11'h3FF, 8'h66}, {3'd7, 11'h000, 8'h77}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // protected when the top (7-bp) address bits are all ones
  function automatic bit is_prot(input int a, input int b);
    int n;
    if (b == 0) return 1'b0;
    if (b == 7) return 1'b1;
    n = 7 - b;
    return ((a >> (11 - n)) == ((1 << n) - 1));
  endfunction

  task automatic t_start();
    bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
  endtask

  task automatic t_stop();
    bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
  endtask

  task automatic t_begin(input bit rd);
    xfer_begin = 1'b1; xfer_read = rd;
    @(negedge clk);
    xfer_begin = 1'b0;
    if (rd) @(negedge clk);
  endtask

  task automatic t_send(input logic [7:0] b, input bit exp_ok, input bit exp_wr, input string tag);
    chk(rx_ready == 1'b1, {tag, " rx_ready"}, rx_ready, 1);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(ack_valid == 1'b1 && ack_ok == exp_ok, {tag, " ack"}, {ack_valid, ack_ok}, {1'b1, exp_ok});
    chk(array_written == exp_wr, {tag, " written"}, array_written, exp_wr);
  endtask

  task automatic t_addr(input int a, input string tag);
    t_send({5'b10110, 3'(a >> 8)}, 1'b1, 1'b0, tag);
    t_send(8'(a), 1'b1, 1'b0, tag);
  endtask

  task automatic t_read(input logic [7:0] exp, input bit last, input string tag);
    chk(tx_valid == 1'b1 && tx_data == exp, {tag, " read"}, {tx_valid, tx_data}, {1'b1, exp});
    tx_ready = 1'b1; @(negedge clk); tx_ready = 1'b0;
    host_ack_valid = 1'b1; host_nack = last;
    @(negedge clk);
    host_ack_valid = 1'b0; host_nack = 1'b0;
    if (!last) @(negedge clk);
  endtask

  task automatic t_rand_read(input int a, input logic [7:0] exp, input string tag);
    t_start(); t_begin(1'b0); t_addr(a, tag);
    t_start(); t_begin(1'b1); t_read(exp, 1'b1, tag);
    t_stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs after reset
    chk(rx_ready == 1 && tx_valid == 0 && ack_valid == 0 && ack_ok == 0 && array_written == 0,
        "R1 reset outputs", {rx_ready, tx_valid, ack_valid, ack_ok, array_written}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R6: fill the whole array, then one more byte wraps onto 0
    t_start(); t_begin(1'b0); t_addr(0, "R2 fill addr");
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = 8'(i * 7 + 3);
      t_send(shadow[i], 1'b1, 1'b1, "R3 fill data");
    end
    shadow[0] = 8'hE1;
    t_send(8'hE1, 1'b1, 1'b1, "R6 write wrap");
    t_stop();

    // R6 R5: sequential read across the top of the array
    t_start(); t_begin(1'b0); t_addr(DEPTH - 2, "R7 addr");
    t_start(); t_begin(1'b1);
    t_read(shadow[DEPTH-2], 1'b0, "R5 seq0");
    t_read(shadow[DEPTH-1], 1'b0, "R5 seq1");
    t_read(shadow[0], 1'b0, "R6 read wrap");
    t_read(shadow[1], 1'b1, "R5 seq3 last");
    // R5: after the final nack a begin without Start is ignored
    t_begin(1'b1);
    chk(tx_valid == 1'b0, "R5 begin after nack ignored", tx_valid, 0);
    t_stop();

    // R4: byte held while tx_ready stays low
    t_start(); t_begin(1'b0); t_addr(12'h123, "R4 addr");
    t_start(); t_begin(1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(tx_valid == 1'b1 && tx_data == shadow[12'h123], "R4 hold", tx_data, shadow[12'h123]);
    end
    t_read(shadow[12'h123], 1'b0, "R4 after hold");
    t_read(shadow[12'h124], 1'b1, "R4 ptr advanced");
    t_stop();

    // R8 R9 R2 R7: vector table of protect settings
    for (int v = 0; v < 12; v++) begin
      int a;
      bit pr;
      a  = int'(VEC[v][18:8]);
      bp = VEC[v][21:19];
      pr = is_prot(a, int'(VEC[v][21:19]));
      t_start(); t_begin(1'b0); t_addr(a, "R2 vec addr");
      t_send(VEC[v][7:0], !pr, !pr, "R8 vec data");
      if (!pr) shadow[a] = VEC[v][7:0];
      else t_send(8'hFF, 1'b0, 1'b0, "R9 locked byte");
      t_stop();
      // current-address read shows whether the pointer advanced
      t_start(); t_begin(1'b1);
      t_read(shadow[pr ? a : (a + 1) % DEPTH], 1'b1, "R9 pointer after data");
      t_stop();
      t_rand_read(a, shadow[a], "R7 vec readback");
    end
    bp = 3'd0;

    // R11: bytes after a Stop are refused and change nothing
    t_start(); t_begin(1'b0); t_addr(12'h200, "R11 addr");
    shadow[12'h200] = 8'h9A;
    t_send(8'h9A, 1'b1, 1'b1, "R11 data");
    t_stop();
    t_send(8'h5B, 1'b0, 1'b0, "R11 after stop");
    t_rand_read(12'h201, shadow[12'h201], "R11 no change");

    // R10: abort drops the byte offered with it
    t_start(); t_begin(1'b0); t_addr(12'h300, "R10 addr");
    shadow[12'h300] = 8'h4C;
    t_send(8'h4C, 1'b1, 1'b1, "R10 first");
    abort = 1'b1; rx_valid = 1'b1; rx_data = 8'hD2;
    @(negedge clk);
    abort = 1'b0; rx_valid = 1'b0;
    chk(ack_ok == 1'b0 && array_written == 1'b0, "R10 aborted byte", {ack_ok, array_written}, 0);
    t_send(8'h6E, 1'b0, 1'b0, "R10 ignored after abort");
    t_rand_read(12'h300, 8'h4C, "R10 committed kept");
    t_rand_read(12'h301, shadow[12'h301], "R10 lost byte");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule